// File: doc/BRIEF.md
# Two-Level Logic Vector Processor

This block executes vector instructions built only from bitwise logic, with no arithmetic. It holds four W-bit operand registers. Each instruction passes through two cascaded levels. The first level is a binary level that combines two operands with AND, OR or XOR, or hands the first operand on unchanged. The second level is a unary level that inverts the vector, packs all of its one bits against the most significant end, or leaves it alone. The outcome is written back to one of the four registers.

Either operand may come from a row of an external associative matrix instead of a register. The block drives the row index and takes the row contents back in the same cycle, so a register holding a query can be combined with a stored row. A separate load port fills registers from outside, and a read port shows any register. A flag reports every cycle whether the current result has any bit set. This flag reduces a quality vector to a single yes/no decision.

There are no states beyond the register contents. Every instruction finishes in the clock it is issued.

Top module: `lvp_core`

## Requirements
- R1: While reset is asserted and after it is released, all four registers read zero and the any-one flag is 0 until an instruction or load changes them.
- R2: The binary field selects the first-level operation on operands A and B: 2'b01 gives A AND B, 2'b10 gives A OR B, 2'b11 gives A XOR B.
- R3: A binary field of 2'b00 passes operand A unchanged to the unary level, so an instruction may be unary only.
- R4: A unary field of 2'b01 inverts every bit of the first-level output.
- R5: A unary field of 2'b10 packs the first-level output: a vector with k ones becomes k contiguous ones in bits W-1 down to W-k, and zeros elsewhere. An all-zero vector stays zero.
- R6: A unary field of 2'b00 leaves the first-level output unchanged, and the reserved value 2'b11 behaves the same way.
- R7: When its matrix-select bit is 1, operand A (or B) is the matrix row data instead of a register. The row index output always equals the instruction's row field.
- R8: A valid instruction writes its result to the register named by its 2-bit destination (0=first register ... 3=fourth) at the next clock edge, and the next instruction sees the new value.
- R9: A load writes its data into the addressed register at the clock edge of the cycle it is presented. If a load and an instruction write the same register, the load value is kept. If they write different registers, both writes happen.
- R10: The any-one flag is the OR of all bits of the current instruction's final result while an instruction is valid, and 0 when none is valid.
- R11: The read port shows the addressed register's stored value without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_bop | input | 2 | Binary level operation code |
| ins_uop | input | 2 | Unary level operation code |
| ins_srca | input | 2 | Register feeding operand A |
| ins_srcb | input | 2 | Register feeding operand B |
| ins_amat | input | 1 | Operand A taken from matrix row |
| ins_bmat | input | 1 | Operand B taken from matrix row |
| ins_row | input | RW | Matrix row index |
| ins_dst | input | 2 | Destination register |
| mat_row_addr | output | RW | Row index presented to the matrix |
| mat_row_data | input | W | Contents of the addressed row |
| ld_en | input | 1 | Load strobe |
| ld_addr | input | 2 | Register to load |
| ld_data | input | W | Value to load |
| rd_addr | input | 2 | Register to show |
| rd_data | output | W | Value of the shown register |
| any_one | output | 1 | OR of all bits of the current result |

## Verification
The any-one flag and the row index are combinational, so they are due in the same cycle the instruction is driven. The bench drives on the falling edge and samples a quarter period later, before the next rising edge. A written-back or loaded value is due one rising edge later. The bench therefore reads it through the read port on the falling edge after that rising edge. Dependent instructions are issued back to back to show that a result is usable by the very next instruction.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

    typedef enum logic [1:0] {
        BOP_PASS = 2'b00,
        BOP_AND  = 2'b01,
        BOP_OR   = 2'b10,
        BOP_XOR  = 2'b11
    } bop_e;

    typedef enum logic [1:0] {
        UOP_KEEP = 2'b00,
        UOP_INV  = 2'b01,
        UOP_PACK = 2'b10,
        UOP_RSV  = 2'b11
    } uop_e;

endpackage

// File: rtl/lvp_binop.sv
module lvp_binop
    import lvp_pkg::*;
#(
    parameter int W = 8
) (
    input  bop_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            BOP_PASS: y = a;
            BOP_AND:  y = a & b;
            BOP_OR:   y = a | b;
            BOP_XOR:  y = a ^ b;
            default:  y = a;
        endcase
    end

endmodule

// File: rtl/lvp_unop.sv
module lvp_unop
    import lvp_pkg::*;
#(
    parameter int W = 8
) (
    input  uop_e         op,
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);

    logic [W-1:0] packed_v;
    int           ones;

    always_comb begin
        ones = 0;
        for (int i = 0; i < W; i++) begin
            ones = ones + int'(a[i]);
        end
        for (int i = 0; i < W; i++) begin
            packed_v[i] = (i >= (W - ones));
        end
    end

    always_comb begin
        unique case (op)
            UOP_KEEP: y = a;
            UOP_INV:  y = ~a;
            UOP_PACK: y = packed_v;
            UOP_RSV:  y = a;
            default:  y = a;
        endcase
    end

endmodule

// File: rtl/lvp_regfile.sv
module lvp_regfile #(
    parameter int W    = 8,
    parameter int NREG = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [W-1:0]  ld_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [W-1:0]  wb_data,
    output logic [W-1:0]  q [NREG]
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[g] <= '0;
            end else if (ld_en && (ld_addr == AW'(g))) begin
                q[g] <= ld_data;
            end else if (wb_en && (wb_addr == AW'(g))) begin
                q[g] <= wb_data;
            end
        end
    end

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> q[$past(ld_addr)] == $past(ld_data)); // R9

    AST_WRITEBACK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !(ld_en && ld_addr == wb_addr)) |=> q[$past(wb_addr)] == $past(wb_data)); // R8

endmodule

// File: rtl/lvp_core.sv
module lvp_core
    import lvp_pkg::*;
#(
    parameter int W    = 8,
    parameter int ROWS = 4,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    input  logic [1:0]    ins_bop,
    input  logic [1:0]    ins_uop,
    input  logic [1:0]    ins_srca,
    input  logic [1:0]    ins_srcb,
    input  logic          ins_amat,
    input  logic          ins_bmat,
    input  logic [RW-1:0] ins_row,
    input  logic [1:0]    ins_dst,
    output logic [RW-1:0] mat_row_addr,
    input  logic [W-1:0]  mat_row_data,
    input  logic          ld_en,
    input  logic [1:0]    ld_addr,
    input  logic [W-1:0]  ld_data,
    input  logic [1:0]    rd_addr,
    output logic [W-1:0]  rd_data,
    output logic          any_one
);

    localparam int NREG = 4;

    logic [W-1:0] regs [NREG];
    logic [W-1:0] opa, opb, lvl1, lvl2;
    bop_e         bop;
    uop_e         uop;

    assign bop          = bop_e'(ins_bop);
    assign uop          = uop_e'(ins_uop);
    assign mat_row_addr = ins_row;

    assign opa = ins_amat ? mat_row_data : regs[ins_srca];
    assign opb = ins_bmat ? mat_row_data : regs[ins_srcb];

    lvp_binop #(.W(W)) u_bin (
        .op (bop),
        .a  (opa),
        .b  (opb),
        .y  (lvl1)
    );

    lvp_unop #(.W(W)) u_un (
        .op (uop),
        .a  (lvl1),
        .y  (lvl2)
    );

    lvp_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .wb_en   (ins_valid),
        .wb_addr (ins_dst),
        .wb_data (lvl2),
        .q       (regs)
    );

    assign rd_data = regs[rd_addr];
    assign any_one = ins_valid && (|lvl2);

    AST_PACK_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_uop == 2'b10) |-> $countones(lvl2) == $countones(lvl1)); // R5

    AST_DOUBLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_bop == 2'b00 && ins_uop == 2'b00) |-> lvl2 == opa); // R3

    AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> !any_one); // R10

    AST_INVERT_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_uop == 2'b01) |-> (lvl2 & lvl1) == '0); // R4

endmodule

// File: tb/lvp_core_tb_top.sv
module lvp_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0;
    logic [1:0]    ins_bop = '0, ins_uop = '0, ins_srca = '0, ins_srcb = '0, ins_dst = '0;
    logic          ins_amat = 1'b0, ins_bmat = 1'b0;
    logic [RW-1:0] ins_row = '0;
    logic [RW-1:0] mat_row_addr;
    logic [W-1:0]  mat_row_data;
    logic          ld_en = 1'b0;
    logic [1:0]    ld_addr = '0, rd_addr = '0;
    logic [W-1:0]  ld_data = '0;
    logic [W-1:0]  rd_data;
    logic          any_one;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        case (mat_row_addr)
            2'd0:    mat_row_data = 8'h0F;
            2'd1:    mat_row_data = 8'hA5;
            2'd2:    mat_row_data = 8'hFF;
            default: mat_row_data = 8'h00;
        endcase
    end

    lvp_core #(.W(W), .ROWS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_bop(ins_bop),
        .ins_uop(ins_uop), .ins_srca(ins_srca), .ins_srcb(ins_srcb),
        .ins_amat(ins_amat), .ins_bmat(ins_bmat), .ins_row(ins_row),
        .ins_dst(ins_dst), .mat_row_addr(mat_row_addr), .mat_row_data(mat_row_data),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .any_one(any_one)
    );

    // {bop, uop, amat, bmat, srca, srcb, row, expected}; regs: 0=C3 1=5A 2=81
    typedef struct packed {
        logic [1:0] bop; logic [1:0] uop; logic am; logic bm;
        logic [1:0] sa; logic [1:0] sb; logic [1:0] row; logic [7:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 2'b00, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0, 8'h42}, // R2 and
        '{2'b10, 2'b00, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0, 8'hDB}, // R2 or
        '{2'b11, 2'b00, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0, 8'h99}, // R2 xor
        '{2'b00, 2'b01, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0, 8'h3C}, // R3 R4
        '{2'b00, 2'b10, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0, 8'hF0}, // R5
        '{2'b01, 2'b00, 1'b0, 1'b1, 2'd0, 2'd0, 2'd1, 8'h81}, // R7 query vs row
        '{2'b11, 2'b01, 1'b0, 1'b0, 2'd1, 2'd2, 2'd0, 8'h24}, // R4 cascade
        '{2'b00, 2'b10, 1'b0, 1'b0, 2'd2, 2'd0, 2'd0, 8'hC0}, // R5
        '{2'b00, 2'b00, 1'b1, 1'b0, 2'd0, 2'd0, 2'd2, 8'hFF}, // R6 R7
        '{2'b00, 2'b10, 1'b1, 1'b0, 2'd0, 2'd0, 2'd3, 8'h00}, // R5 zero
        '{2'b10, 2'b10, 1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 8'hFC}, // R5 R7
        '{2'b01, 2'b11, 1'b0, 1'b0, 2'd0, 2'd2, 2'd0, 8'h81}  // R6 reserved
    };

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic issue(input logic [1:0] bop, input logic [1:0] uop, input logic am, input logic bm,
                         input logic [1:0] sa, input logic [1:0] sb, input logic [1:0] row, input logic [1:0] dst);
        @(negedge clk);
        ins_valid = 1'b1; ins_bop = bop; ins_uop = uop; ins_amat = am; ins_bmat = bm;
        ins_srca = sa; ins_srcb = sb; ins_row = row; ins_dst = dst;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [W-1:0] exp, input string req);
        rd_addr = a;
        #1;
        chk(rd_data == exp, req, rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1'b0, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        #(CLK_PERIOD * 2);
        for (int r = 0; r < 4; r++) read_chk(2'(r), 8'h00, "R1 reset in progress");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        for (int r = 0; r < 4; r++) read_chk(2'(r), 8'h00, "R1 after reset");
        chk(any_one == 1'b0, "R1 flag", {7'b0, any_one}, 8'h00);

        // R9 R11 loads
        load(2'd0, 8'hC3); load(2'd1, 8'h5A); load(2'd2, 8'h81);
        read_chk(2'd0, 8'hC3, "R9 R11 load 0");
        read_chk(2'd1, 8'h5A, "R9 R11 load 1");
        read_chk(2'd2, 8'h81, "R9 R11 load 2");

        // table walk
        for (int v = 0; v < NV; v++) begin
            issue(VECS[v].bop, VECS[v].uop, VECS[v].am, VECS[v].bm, VECS[v].sa, VECS[v].sb, VECS[v].row, 2'd3);
            #(CLK_PERIOD/4);
            chk(any_one == (VECS[v].exp != 0), $sformatf("R10 flag vec %0d", v), {7'b0, any_one}, {7'b0, VECS[v].exp != 0});
            chk(mat_row_addr == VECS[v].row, $sformatf("R7 row addr vec %0d", v), {6'b0, mat_row_addr}, {6'b0, VECS[v].row});
            @(negedge clk);
            ins_valid = 1'b0;
            read_chk(2'd3, VECS[v].exp, $sformatf("R2-table R8 vec %0d", v));
        end

        // R10 idle flag with nonzero data around
        #1;
        chk(any_one == 1'b0, "R10 idle", {7'b0, any_one}, 8'h00);

        // R8 back-to-back: r3 = ~C3 = 3C, then r3 = r3 | r0 = FF
        issue(2'b00, 2'b01, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd3);
        issue(2'b10, 2'b00, 1'b0, 1'b0, 2'd3, 2'd0, 2'd0, 2'd3);
        @(negedge clk); ins_valid = 1'b0;
        read_chk(2'd3, 8'hFF, "R8 back-to-back");

        // R9 load beats write-back on same register
        issue(2'b10, 2'b00, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0, 2'd3);
        ld_en = 1'b1; ld_addr = 2'd3; ld_data = 8'h11;
        @(negedge clk); ins_valid = 1'b0; ld_en = 1'b0;
        read_chk(2'd3, 8'h11, "R9 load priority");

        // R9 load and write-back to different registers
        issue(2'b01, 2'b00, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0, 2'd3);
        ld_en = 1'b1; ld_addr = 2'd2; ld_data = 8'h77;
        @(negedge clk); ins_valid = 1'b0; ld_en = 1'b0;
        read_chk(2'd3, 8'h42, "R9 parallel write-back");
        read_chk(2'd2, 8'h77, "R9 parallel load");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule